// File: doc/BRIEF.md
# Flash Query Response Formatter

This block builds the read data that a parallel flash bank returns while it sits in table-query mode or identifier mode. The bank is a row of identical flash devices placed side by side on a data bus. Each device may be a wide part used in byte mode. The command decoder elsewhere selects the mode and raises a read strobe. This block turns the byte address into a table index, looks up the per-device answer and replicates it across every device lane. It assembles reads wider than the bank from several bank-wide lookups. The result is registered.

The table is computed at elaboration from parameters. It covers the identification signature, the command-set code, the device size and the erase-block geometry. The manufacturer and device codes are also parameters. Bank width, device width, maximum device width and the widest read are powers of two and are checked at elaboration. The reset input is expected to be already synchronised to `clk` on release.

Top module: `qfmt_top`

## Requirements
- R1: The table index of a lookup is its byte address shifted right by log2(bank bytes) + log2(max device bytes) − log2(device bytes). With the defaults (2, 1, 2) the shift is 2, so the two lowest address bits have no effect.
- R2: A table index of 82 (0x52) or above returns zero, whatever its low bits.
- R3: The table holds the bytes 0x51, 0x52, 0x59 at indices 0x10..0x12 and the command-set code 0x0001, low byte first, at 0x13..0x14. It holds one erase region at 0x2C, (blocks − 1) low byte at 0x2D and log2(device size) at 0x27.
- R4: When device width differs from max device width, only device width 1 with bank width at most 4 is served, and the table byte then fills every byte of the bank. Any other such combination returns zero in table mode.
- R5: The single-device answer is copied into every device-width lane of the bank. In table mode with equal widths the byte is zero-extended inside its lane.
- R6: In identifier mode (mode = 1) the low 8 bits of the index select the manufacturer code at 0 and the device code at 1, each cut to the device width. Every other value returns zero.
- R7: A read wider than the bank is made of bank-wide lookups at addr, addr + bank, addr + 2·bank and so on. The first lookup fills the lowest lane.
- R8: width_code 0, 1, 2 and 3 request 1, 2, 4 and 8 bytes. Every response byte at or above the requested count is zero.
- R9: rd_en, mode, width_code and addr are sampled at a rising edge. rsp_valid is high in exactly the cycle after a strobe, with the answer on rsp_data. rsp_data holds its value while no strobe arrives.
- R10: During reset rsp_valid is 0 and rsp_data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| mode | input | 1 | 0 = table query, 1 = identifier |
| width_code | input | 2 | log2 of requested read bytes |
| addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Response valid, one cycle after rd_en |
| rsp_data | output | ACC_BYTES*8 | Formatted response, lowest lane first |

## Verification
Every result of this block appears on the first rising edge after the strobe, because one register sits between the inputs and the outputs. Held data is due on every later edge until the next strobe. The bench drives inputs on the falling edge. It reads rsp_valid and rsp_data on the following falling edge, half a cycle after the edge that loaded them. For back-to-back reads, it checks the first answer in the same half-cycle in which it drives the second request. An idle cycle after a read then confirms that rsp_valid drops and that rsp_data keeps the last answer.

// File: rtl/qfmt_pkg.sv
package qfmt_pkg;

  typedef enum logic {
    QF_TABLE = 1'b0,
    QF_IDENT = 1'b1
  } qf_mode_e;

  localparam int QF_TABLE_LEN = 82;

  function automatic bit qf_is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/qfmt_table.sv
module qfmt_table
  import qfmt_pkg::*;
#(
  parameter int IDX_W       = 12,
  parameter int BLOCKS      = 64,
  parameter int BLOCK_BYTES = 65536,
  parameter int WBUF_LOG2   = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       tbl_byte
);

  localparam logic [31:0] BLK_M1    = 32'(BLOCKS - 1);
  localparam logic [31:0] BLK_SIZE  = 32'(BLOCK_BYTES);
  localparam logic [7:0]  SIZE_LOG2 = 8'($clog2(BLOCKS * BLOCK_BYTES));
  localparam logic [7:0]  WBUF_L    = 8'(WBUF_LOG2);

  logic       in_range;
  logic [7:0] raw;

  assign in_range = (32'(idx) < QF_TABLE_LEN);

  always_comb begin
    raw = 8'h00;
    unique case (idx[6:0])
      7'h10:   raw = 8'h51;
      7'h11:   raw = 8'h52;
      7'h12:   raw = 8'h59;
      7'h13:   raw = 8'h01;
      7'h14:   raw = 8'h00;
      7'h15:   raw = 8'h31;
      7'h27:   raw = SIZE_LOG2;
      7'h28:   raw = 8'h02;
      7'h2A:   raw = WBUF_L;
      7'h2C:   raw = 8'h01;
      7'h2D:   raw = BLK_M1[7:0];
      7'h2E:   raw = BLK_M1[15:8];
      7'h2F:   raw = BLK_SIZE[15:8];
      7'h30:   raw = BLK_SIZE[23:16];
      default: raw = 8'h00;
    endcase
  end

  assign tbl_byte = in_range ? raw : 8'h00;

endmodule

// File: rtl/qfmt_lane.sv
module qfmt_lane
  import qfmt_pkg::*;
#(
  parameter int          ADDR_W        = 12,
  parameter int          BANK_BYTES    = 2,
  parameter int          DEV_BYTES     = 1,
  parameter int          MAX_DEV_BYTES = 2,
  parameter int          SHIFT         = 2,
  parameter int          BLOCKS        = 64,
  parameter int          BLOCK_BYTES   = 65536,
  parameter int          WBUF_LOG2     = 5,
  parameter logic [15:0] MANUF_ID      = 16'h0089,
  parameter logic [15:0] DEVICE_ID     = 16'h0018
) (
  input  logic [ADDR_W-1:0]       lane_addr,
  input  qf_mode_e                mode,
  output logic [BANK_BYTES*8-1:0] lane_rsp
);

  localparam int DW        = DEV_BYTES * 8;
  localparam int NDEV      = BANK_BYTES / DEV_BYTES;
  localparam bit NARROW    = (DEV_BYTES != MAX_DEV_BYTES);
  localparam bit SUPPORTED = !NARROW || ((DEV_BYTES == 1) && (BANK_BYTES <= 4));

  logic [ADDR_W-1:0] idx;
  logic [7:0]        tbl_byte;
  logic [63:0]       id_word;
  logic [DW-1:0]     dev_rsp;

  assign idx = lane_addr >> SHIFT;

  qfmt_table #(
    .IDX_W      (ADDR_W),
    .BLOCKS     (BLOCKS),
    .BLOCK_BYTES(BLOCK_BYTES),
    .WBUF_LOG2  (WBUF_LOG2)
  ) i_table (
    .idx     (idx),
    .tbl_byte(tbl_byte)
  );

  always_comb begin
    id_word = '0;
    if (idx[7:0] == 8'd0)      id_word = 64'(MANUF_ID);
    else if (idx[7:0] == 8'd1) id_word = 64'(DEVICE_ID);
  end

  always_comb begin
    dev_rsp = '0;
    if (mode == QF_IDENT) begin
      dev_rsp = id_word[DW-1:0];
    end else if (SUPPORTED) begin
      dev_rsp = DW'(tbl_byte);
    end
  end

  assign lane_rsp = {NDEV{dev_rsp}};

endmodule

// File: rtl/qfmt_top.sv
module qfmt_top
  import qfmt_pkg::*;
#(
  parameter int          ADDR_W        = 12,
  parameter int          BANK_BYTES    = 2,
  parameter int          DEV_BYTES     = 1,
  parameter int          MAX_DEV_BYTES = 2,
  parameter int          ACC_BYTES     = 8,
  parameter int          BLOCKS        = 64,
  parameter int          BLOCK_BYTES   = 65536,
  parameter int          WBUF_LOG2     = 5,
  parameter logic [15:0] MANUF_ID      = 16'h0089,
  parameter logic [15:0] DEVICE_ID     = 16'h0018
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic                   mode,
  input  logic [1:0]             width_code,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   rsp_valid,
  output logic [ACC_BYTES*8-1:0] rsp_data
);

  localparam int SHIFT  = $clog2(BANK_BYTES) + $clog2(MAX_DEV_BYTES) - $clog2(DEV_BYTES);
  localparam int NQ     = ACC_BYTES / BANK_BYTES;
  localparam int BANK_W = BANK_BYTES * 8;
  localparam int ACC_W  = ACC_BYTES * 8;

  if (!qf_is_pow2(BANK_BYTES) || !qf_is_pow2(DEV_BYTES) ||
      !qf_is_pow2(MAX_DEV_BYTES) || !qf_is_pow2(ACC_BYTES)) begin : g_bad_pow2
    $error("qfmt_top: widths must be powers of two");
  end
  if ((DEV_BYTES > BANK_BYTES) || (DEV_BYTES > MAX_DEV_BYTES) ||
      (BANK_BYTES > ACC_BYTES) || (ACC_BYTES > 8) || (ADDR_W < 8)) begin : g_bad_range
    $error("qfmt_top: width parameters out of range");
  end

  qf_mode_e         mode_e;
  logic [3:0]       nbytes;
  logic [ACC_W-1:0] lanes_cat;
  logic [ACC_W-1:0] fmt;

  logic             valid_d, valid_q;
  logic [ACC_W-1:0] data_d, data_q;

  assign mode_e = qf_mode_e'(mode);
  assign nbytes = 4'd1 << width_code;

  for (genvar k = 0; k < NQ; k++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    logic [BANK_W-1:0] lane_rsp;

    assign lane_addr = addr + ADDR_W'(k * BANK_BYTES);

    qfmt_lane #(
      .ADDR_W       (ADDR_W),
      .BANK_BYTES   (BANK_BYTES),
      .DEV_BYTES    (DEV_BYTES),
      .MAX_DEV_BYTES(MAX_DEV_BYTES),
      .SHIFT        (SHIFT),
      .BLOCKS       (BLOCKS),
      .BLOCK_BYTES  (BLOCK_BYTES),
      .WBUF_LOG2    (WBUF_LOG2),
      .MANUF_ID     (MANUF_ID),
      .DEVICE_ID    (DEVICE_ID)
    ) i_lane (
      .lane_addr(lane_addr),
      .mode     (mode_e),
      .lane_rsp (lane_rsp)
    );

    assign lanes_cat[k*BANK_W +: BANK_W] =
      (32'(nbytes) > k * BANK_BYTES) ? lane_rsp : '0;
  end

  always_comb begin
    fmt = lanes_cat;
    for (int b = 0; b < ACC_BYTES; b++) begin
      if (b >= 32'(nbytes)) fmt[b*8 +: 8] = 8'h00;
    end
  end

  always_comb begin
    valid_d = rd_en;
    data_d  = rd_en ? fmt : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (rd_en) data_q <= data_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_data  = data_q;

endmodule

// File: rtl/qfmt_checker.sv
module qfmt_checker
  import qfmt_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int BANK_BYTES    = 2,
  parameter int DEV_BYTES     = 1,
  parameter int MAX_DEV_BYTES = 2,
  parameter int ACC_BYTES     = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_en,
  input logic                   mode,
  input logic [1:0]             width_code,
  input logic [ADDR_W-1:0]      addr,
  input logic                   rsp_valid,
  input logic [ACC_BYTES*8-1:0] rsp_data
);

  localparam int SHIFT  = $clog2(BANK_BYTES) + $clog2(MAX_DEV_BYTES) - $clog2(DEV_BYTES);
  localparam int LGBANK = $clog2(BANK_BYTES);
  localparam int NDEV   = BANK_BYTES / DEV_BYTES;

  logic [ADDR_W-1:0] idx_in;
  logic              one_lane;

  assign idx_in   = addr >> SHIFT;
  assign one_lane = (32'(width_code) <= LGBANK);

  p_valid_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);

  p_no_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);

  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rsp_data));

  p_width_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((rsp_data >> (8 << $past(width_code))) == '0));

  p_table_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (mode == QF_TABLE) && one_lane && (32'(idx_in) >= QF_TABLE_LEN))
      |=> (rsp_data == '0));

  p_ident_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (mode == QF_IDENT) && one_lane && (idx_in[7:0] > 8'd1))
      |=> (rsp_data == '0));

  p_lane_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (32'(width_code) == LGBANK))
      |=> (rsp_data[BANK_BYTES*8-1:0] == {NDEV{rsp_data[DEV_BYTES*8-1:0]}}));

endmodule

bind qfmt_top qfmt_checker #(
  .ADDR_W       (ADDR_W),
  .BANK_BYTES   (BANK_BYTES),
  .DEV_BYTES    (DEV_BYTES),
  .MAX_DEV_BYTES(MAX_DEV_BYTES),
  .ACC_BYTES    (ACC_BYTES)
) i_qfmt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .mode      (mode),
  .width_code(width_code),
  .addr      (addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data)
);

// File: tb/test_qfmt_top.sv
`timescale 1ns/1ps
module test_qfmt_top;

  logic        clk;
  logic        rst_n;
  logic        rd_en;
  logic        mode;
  logic [1:0]  width_code;
  logic [11:0] addr;
  logic        rsp_valid;
  logic [63:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  qfmt_top i_qfmt_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .mode      (mode),
    .width_code(width_code),
    .addr      (addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic m, input logic [1:0] wc,
                    input logic [63:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a; mode = m; width_code = wc;
    @(negedge clk);
    rd_en = 1'b0;
    check({tag, " valid"}, 64'(rsp_valid), 64'd1);
    check(tag, rsp_data, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rd_en = 1'b0; mode = 1'b0; width_code = 2'd0; addr = '0;
    repeat (3) @(negedge clk);
    check("R10 valid in reset", 64'(rsp_valid), 64'd0);
    check("R10 data in reset", rsp_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_table;
    rd(12'h040, 1'b0, 2'd0, 64'h51, "R3 R8 signature byte 0x10");
    rd(12'h043, 1'b0, 2'd0, 64'h51, "R1 low address bits ignored");
    rd(12'h044, 1'b0, 2'd1, 64'h5252, "R3 R4 R5 index 0x11 both bytes");
    rd(12'h048, 1'b0, 2'd1, 64'h5959, "R3 index 0x12");
    rd(12'h04C, 1'b0, 2'd1, 64'h0101, "R3 command set low byte");
    rd(12'h050, 1'b0, 2'd1, 64'h0000, "R3 command set high byte");
    rd(12'h09C, 1'b0, 2'd0, 64'h16, "R3 size log2");
    rd(12'h0B0, 1'b0, 2'd1, 64'h0101, "R3 region count");
    rd(12'h0B4, 1'b0, 2'd0, 64'h3F, "R3 blocks minus one");
  endtask

  task automatic t_bound;
    rd(12'h144, 1'b0, 2'd1, 64'h0, "R2 last index 0x51");
    rd(12'h148, 1'b0, 2'd1, 64'h0, "R2 index 0x52");
    rd(12'h240, 1'b0, 2'd1, 64'h0, "R2 index 0x90 aliases signature");
  endtask

  task automatic t_ident;
    rd(12'h000, 1'b1, 2'd1, 64'h8989, "R6 manufacturer code");
    rd(12'h004, 1'b1, 2'd1, 64'h1818, "R6 device code");
    rd(12'h008, 1'b1, 2'd1, 64'h0, "R6 other index zero");
    rd(12'h402, 1'b1, 2'd1, 64'h8989, "R6 upper index bits ignored");
  endtask

  task automatic t_wide;
    rd(12'h044, 1'b0, 2'd3, 64'h5959_5959_5252_5252, "R7 eight byte table read");
    rd(12'h04C, 1'b0, 2'd3, 64'h0000_0000_0101_0101, "R7 eight byte command set");
    rd(12'h000, 1'b1, 2'd3, 64'h1818_1818_8989_8989, "R7 eight byte identifier");
    rd(12'h004, 1'b1, 2'd2, 64'h0000_0000_1818_1818, "R7 R8 four byte identifier");
  endtask

  task automatic t_timing;
    @(negedge clk);
    rd_en = 1'b1; addr = 12'h040; mode = 1'b0; width_code = 2'd1;
    @(negedge clk);
    check("R9 first of pair valid", 64'(rsp_valid), 64'd1);
    check("R9 first of pair data", rsp_data, 64'h5151);
    addr = 12'h004; mode = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 second of pair data", rsp_data, 64'h1818);
    addr = 12'h048; mode = 1'b0;
    @(negedge clk);
    check("R9 valid drops when idle", 64'(rsp_valid), 64'd0);
    check("R9 data held when idle", rsp_data, 64'h1818);
  endtask

  initial begin
    t_reset();
    t_table();
    t_bound();
    t_ident();
    t_wide();
    t_timing();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule